// File: doc/BRIEF.md
# Waveform charge and timing extractor

This block sits behind the readout of one digitizer channel and turns each recorded waveform into a short physics record. Samples arrive as 12-bit unsigned values, each qualified by a valid strobe. A start marker tags the first sample of a waveform and an end marker tags its last. The leading samples of every waveform form a baseline estimate. That baseline is removed from every later sample. The corrected samples are then summed over a programmable window to give a charge. The same corrected stream is compared against a programmable threshold to locate the pulse arrival index. Together these stand in for a separate discriminator and time-to-digital converter.

A normal pulse is reduced to the charge and the arrival index. If the corrected signal crosses the threshold, drops well back, and crosses it again, two pulses overlap. In that case the block raises a keep strobe so that the surrounding system stores the raw waveform for later fitting. Waveforms are counted up to 1024 samples. Samples past that index take no part in the results.

Top module: `wf_charge_time`

## Requirements
- R1: After synchronous reset, out_done and out_keep are low and out_charge, out_time, out_nohit and out_pileup are zero.
- R2: A sample is taken when in_valid is high and either in_start is high (it becomes index 0 of a new waveform, abandoning any unfinished one) or a waveform is open. Samples with in_valid low, and valid samples while no waveform is open, have no effect on any output. The sample with in_end high is the last one included.
- R3: The baseline is the sum of samples 0 to 15 shifted right by 4 (floor of their mean). For every sample with index 16 or above, the corrected value is sample minus baseline as a signed number.
- R4: out_charge is the signed 21-bit sum of corrected values over post-baseline positions k = index - 16 with k < cfg_win_len. Even 255 full-scale samples do not overflow it.
- R5: out_time is the first k whose corrected value is greater than or equal to cfg_threshold, and out_nohit is 0. If no sample reaches the threshold, out_nohit is 1 and out_time is 0.
- R6: out_pileup is 1 when, after the first crossing, a later sample's corrected value is strictly below cfg_threshold >> 1 and a still later sample again reaches cfg_threshold.
- R7: out_done is high for exactly the one cycle after the clock edge that takes the end sample. Results change only at that edge and hold until the next one.
- R8: out_keep pulses together with out_done exactly when out_pileup of that result is 1.
- R9: A waveform that ends before index 16 reports charge 0, out_nohit 1 and out_pileup 0. A single sample carrying both markers is such a waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| in_start | input | 1 | First sample of a waveform |
| in_end | input | 1 | Last sample of a waveform |
| in_sample | input | 12 | Unsigned sample value |
| cfg_threshold | input | 12 | Crossing threshold on corrected samples |
| cfg_win_len | input | 8 | Integration window length in samples |
| out_done | output | 1 | One-cycle result strobe |
| out_keep | output | 1 | One-cycle request to retain the raw waveform |
| out_charge | output | 21 | Signed integrated charge |
| out_time | output | 10 | Arrival index after the baseline region |
| out_nohit | output | 1 | No sample reached the threshold |
| out_pileup | output | 1 | A second pulse was detected |

## Verification
The end marker can land on the same sample as the first threshold crossing, or as the re-crossing that proves pile-up. The result must then include that final sample: the hit index, or the keep strobe, must appear in the done cycle. Directed waveforms place the crossing and the re-crossing exactly on the last sample. Random pulse trains with random gaps reach the same collision by chance. Every record is compared with a model that applies the same rules to the stored sample list.

// File: rtl/wf_pkg.sv
`timescale 1ns/1ps
package wf_pkg;
    localparam int WF_SAMPLE_W  = 12;
    localparam int WF_WIN_W     = 8;
    localparam int WF_IDX_W     = 10;
    localparam int WF_BASE_LOG2 = 4;

    typedef enum logic {
        WF_IDLE = 1'b0,
        WF_OPEN = 1'b1
    } wf_state_e;

    // per-sample steering decoded by the sequencer
    typedef struct packed {
        logic take;
        logic first;
        logic last;
        logic base;
        logic body;
    } samp_ctl_t;
endpackage

// File: rtl/wf_baseline.sv
`timescale 1ns/1ps
module wf_baseline #(
    parameter int SAMPLE_W  = 12,
    parameter int BASE_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic                first,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] baseline
);
    localparam int SUM_W = SAMPLE_W + BASE_LOG2;

    logic [SUM_W-1:0] sum_q;

    always_ff @(posedge clk) begin
        if (rst)
            sum_q <= '0;
        else if (take && first)
            sum_q <= SUM_W'(sample);
        else if (take)
            sum_q <= sum_q + SUM_W'(sample);
    end

    assign baseline = sum_q[SUM_W-1:BASE_LOG2];
endmodule

// File: rtl/wf_integrator.sv
`timescale 1ns/1ps
module wf_integrator #(
    parameter int CORR_W = 13,
    parameter int WIN_W  = 8,
    parameter int IDX_W  = 10,
    parameter int ACC_W  = 21
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     take,
    input  logic                     first,
    input  logic                     body,
    input  logic [IDX_W-1:0]         k,
    input  logic [WIN_W-1:0]         win_len,
    input  logic signed [CORR_W-1:0] corr,
    output logic signed [ACC_W-1:0]  acc_next
);
    localparam int CMP_W = (IDX_W > WIN_W) ? IDX_W : WIN_W;

    logic signed [ACC_W-1:0] acc_q;
    logic                    in_win;

    assign in_win = CMP_W'(k) < CMP_W'(win_len);

    always_comb begin
        acc_next = first ? '0 : acc_q;
        if (take && body && in_win)
            acc_next = acc_next + {{(ACC_W-CORR_W){corr[CORR_W-1]}}, corr};
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (take)
            acc_q <= acc_next;
    end

    // R4: a new waveform starts from an empty sum
    assert_clear_on_start_R4: assert property (@(posedge clk) disable iff (rst)
        (take && first) |=> (acc_q == '0));
endmodule

// File: rtl/wf_hitfind.sv
`timescale 1ns/1ps
module wf_hitfind #(
    parameter int SAMPLE_W = 12,
    parameter int CORR_W   = 13,
    parameter int IDX_W    = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     take,
    input  logic                     first,
    input  logic                     body,
    input  logic [IDX_W-1:0]         k,
    input  logic signed [CORR_W-1:0] corr,
    input  logic [SAMPLE_W-1:0]      thr,
    output logic                     hit_next,
    output logic                     pile_next,
    output logic [IDX_W-1:0]         time_next
);
    logic             hit_q, fallen_q, pile_q;
    logic [IDX_W-1:0] time_q;
    logic             hit_c, fallen_c, pile_c, fallen_next;
    logic             above, below;

    assign above = corr >= $signed({1'b0, thr});
    assign below = corr <  $signed({2'b00, thr[SAMPLE_W-1:1]});

    always_comb begin
        hit_c       = first ? 1'b0 : hit_q;
        fallen_c    = first ? 1'b0 : fallen_q;
        pile_c      = first ? 1'b0 : pile_q;
        time_next   = first ? '0   : time_q;
        hit_next    = hit_c;
        fallen_next = fallen_c;
        pile_next   = pile_c;
        if (take && body) begin
            pile_next   = pile_c   | (hit_c & fallen_c & above);
            fallen_next = fallen_c | (hit_c & below);
            if (!hit_c && above) begin
                hit_next  = 1'b1;
                time_next = k;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q    <= 1'b0;
            fallen_q <= 1'b0;
            pile_q   <= 1'b0;
            time_q   <= '0;
        end else if (take) begin
            hit_q    <= hit_next;
            fallen_q <= fallen_next;
            pile_q   <= pile_next;
            time_q   <= time_next;
        end
    end

    // R6: a second pulse can only follow a crossing and a dip
    assert_pile_needs_dip_R6: assert property (@(posedge clk) disable iff (rst)
        pile_q |-> (hit_q && fallen_q));
endmodule

// File: rtl/wf_charge_time.sv
`timescale 1ns/1ps
module wf_charge_time
    import wf_pkg::*;
#(
    parameter int SAMPLE_W  = WF_SAMPLE_W,
    parameter int WIN_W     = WF_WIN_W,
    parameter int IDX_W     = WF_IDX_W,
    parameter int BASE_LOG2 = WF_BASE_LOG2
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_valid,
    input  logic                                  in_start,
    input  logic                                  in_end,
    input  logic [SAMPLE_W-1:0]                   in_sample,
    input  logic [SAMPLE_W-1:0]                   cfg_threshold,
    input  logic [WIN_W-1:0]                      cfg_win_len,
    output logic                                  out_done,
    output logic                                  out_keep,
    output logic signed [SAMPLE_W+WIN_W:0]        out_charge,
    output logic [IDX_W-1:0]                      out_time,
    output logic                                  out_nohit,
    output logic                                  out_pileup
);
    localparam int CORR_W  = SAMPLE_W + 1;
    localparam int ACC_W   = SAMPLE_W + 1 + WIN_W;
    localparam int CNT_W   = IDX_W + 1;
    localparam int BASE_N  = 1 << BASE_LOG2;
    localparam int MAX_LEN = 1 << IDX_W;

    wf_state_e               state_q;
    logic [CNT_W-1:0]        cnt_q, cur;
    logic                    in_range;
    samp_ctl_t               ctl;
    logic [IDX_W-1:0]        k;
    logic [SAMPLE_W-1:0]     baseline;
    logic signed [CORR_W-1:0] corr;
    logic signed [ACC_W-1:0] acc_next;
    logic                    hit_next, pile_next;
    logic [IDX_W-1:0]        time_next;

    // sample steering
    assign cur       = in_start ? '0 : cnt_q;
    assign in_range  = cur < CNT_W'(MAX_LEN);
    assign ctl.take  = in_valid & (in_start | (state_q == WF_OPEN));
    assign ctl.first = in_start;
    assign ctl.last  = in_end;
    assign ctl.base  = cur < CNT_W'(BASE_N);
    assign ctl.body  = !ctl.base && in_range;
    assign k         = IDX_W'(cur - CNT_W'(BASE_N));
    assign corr      = $signed({1'b0, in_sample}) - $signed({1'b0, baseline});

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WF_IDLE;
            cnt_q   <= '0;
        end else if (ctl.take) begin
            state_q <= ctl.last ? WF_IDLE : WF_OPEN;
            cnt_q   <= in_range ? cur + 1'b1 : cur;
        end
    end

    wf_baseline #(.SAMPLE_W(SAMPLE_W), .BASE_LOG2(BASE_LOG2)) u_base (
        .clk      (clk),
        .rst      (rst),
        .take     (ctl.take && ctl.base),
        .first    (ctl.first),
        .sample   (in_sample),
        .baseline (baseline)
    );

    wf_integrator #(.CORR_W(CORR_W), .WIN_W(WIN_W), .IDX_W(IDX_W), .ACC_W(ACC_W)) u_int (
        .clk      (clk),
        .rst      (rst),
        .take     (ctl.take),
        .first    (ctl.first),
        .body     (ctl.body),
        .k        (k),
        .win_len  (cfg_win_len),
        .corr     (corr),
        .acc_next (acc_next)
    );

    wf_hitfind #(.SAMPLE_W(SAMPLE_W), .CORR_W(CORR_W), .IDX_W(IDX_W)) u_hit (
        .clk       (clk),
        .rst       (rst),
        .take      (ctl.take),
        .first     (ctl.first),
        .body      (ctl.body),
        .k         (k),
        .corr      (corr),
        .thr       (cfg_threshold),
        .hit_next  (hit_next),
        .pile_next (pile_next),
        .time_next (time_next)
    );

    // result register, loaded by the end sample
    always_ff @(posedge clk) begin
        if (rst) begin
            out_done   <= 1'b0;
            out_keep   <= 1'b0;
            out_charge <= '0;
            out_time   <= '0;
            out_nohit  <= 1'b0;
            out_pileup <= 1'b0;
        end else begin
            out_done <= ctl.take && ctl.last;
            out_keep <= ctl.take && ctl.last && pile_next;
            if (ctl.take && ctl.last) begin
                out_charge <= acc_next;
                out_time   <= hit_next ? time_next : '0;
                out_nohit  <= !hit_next;
                out_pileup <= pile_next;
            end
        end
    end

    // R7: a result strobe is always caused by an accepted end marker
    assert_done_after_end_R7: assert property (@(posedge clk) disable iff (rst)
        out_done |-> $past(in_valid && in_end));

    // R8: keep only accompanies a pile-up result
    assert_keep_with_pileup_R8: assert property (@(posedge clk) disable iff (rst)
        out_keep |-> (out_done && out_pileup));

    // R5: a missing hit reports index zero and no pile-up
    assert_nohit_clean_R5: assert property (@(posedge clk) disable iff (rst)
        (out_done && out_nohit) |-> (out_time == '0 && !out_pileup));
endmodule

// File: tb/test_wf_charge_time.sv
`timescale 1ns/1ps
module test_wf_charge_time;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0;
    logic [11:0] in_sample = '0;
    logic [11:0] cfg_threshold = 12'd100;
    logic [7:0]  cfg_win_len = 8'd64;
    logic        out_done, out_keep, out_nohit, out_pileup;
    logic signed [20:0] out_charge;
    logic [9:0]  out_time;

    int vectors = 0;
    int errors  = 0;
    int w [0:1023];
    int e_charge, e_time, e_nohit, e_pile;
    int prev_charge;
    bit have_prev = 0;

    always #2.5 clk = ~clk;

    wf_charge_time i_wf_charge_time (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start), .in_end(in_end),
        .in_sample(in_sample), .cfg_threshold(cfg_threshold), .cfg_win_len(cfg_win_len),
        .out_done(out_done), .out_keep(out_keep), .out_charge(out_charge),
        .out_time(out_time), .out_nohit(out_nohit), .out_pileup(out_pileup)
    );

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference rules for a stored waveform of n samples
    task automatic model(int n);
        int base = 0, acc = 0, hit = 0, fallen = 0, pile = 0, tm = 0;
        int thr = int'(cfg_threshold);
        int win = int'(cfg_win_len);
        if (n >= 16) begin
            for (int i = 0; i < 16; i++) base += w[i];
            base = base / 16;
        end
        for (int i = 16; i < n; i++) begin
            int c = w[i] - base;
            int kk = i - 16;
            int p_hit = hit, p_fall = fallen;
            if (kk < win) acc += c;
            if (p_hit && p_fall && c >= thr) pile = 1;
            if (p_hit && c < thr / 2) fallen = 1;
            if (!p_hit && c >= thr) begin hit = 1; tm = kk; end
        end
        e_charge = acc; e_time = tm; e_nohit = !hit; e_pile = pile;
    endtask

    task automatic idle(int n, bit garbage);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) check("R2 no done while idle", out_done, 0);
            in_valid  = garbage ? 1'($urandom) : 1'b0;
            in_start  = 1'b0;
            in_end    = garbage ? 1'($urandom) : 1'b0;
            in_sample = 12'($urandom);
        end
    endtask

    task automatic send(int n, bit gaps, bit close);
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                int g = $urandom_range(0, 3) == 0 ? $urandom_range(1, 2) : 0;
                for (int j = 0; j < g; j++) begin
                    @(negedge clk);
                    in_valid = 1'b0; in_start = 1'($urandom); in_end = 1'($urandom);
                    in_sample = 12'($urandom);
                end
            end
            @(negedge clk);
            if (have_prev && i == n / 2)
                check("R7 result held during next waveform", int'(out_charge), prev_charge);
            in_valid  = 1'b1;
            in_start  = (i == 0);
            in_end    = close && (i == n - 1);
            in_sample = 12'(w[i]);
        end
    endtask

    task automatic run(string tag, int n, bit gaps);
        model(n);
        send(n, gaps, 1'b1);
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
        check({tag, " R7 done"}, out_done, 1);
        check({tag, " R4 charge"}, int'(out_charge), e_charge);
        check({tag, " R5 time"}, int'(out_time), e_time);
        check({tag, " R5 nohit"}, out_nohit, e_nohit);
        check({tag, " R6 pileup"}, out_pileup, e_pile);
        check({tag, " R8 keep"}, out_keep, e_pile);
        @(negedge clk);
        check({tag, " R7 done single"}, out_done, 0);
        check({tag, " R8 keep single"}, out_keep, 0);
        prev_charge = e_charge;
        have_prev = 1;
    endtask

    function automatic int clamp(int v);
        return v < 0 ? 0 : (v > 4095 ? 4095 : v);
    endfunction

    // flat baseline with optional triangular pulses
    task automatic shape(int n, int base, int noise, int p1, int a1, int p2, int a2);
        for (int i = 0; i < n; i++) begin
            int v = base + (noise > 0 ? $urandom_range(0, 2 * noise) - noise : 0);
            if (a1 != 0 && i >= p1 && i < p1 + 8) v += a1 * (8 - (i - p1)) / 8;
            if (a2 != 0 && i >= p2 && i < p2 + 8) v += a2 * (8 - (i - p2)) / 8;
            w[i] = clamp(v);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 done", out_done, 0);
        check("R1 keep", out_keep, 0);
        check("R1 charge", int'(out_charge), 0);
        check("R1 time", int'(out_time), 0);
        check("R1 nohit", out_nohit, 0);
        check("R1 pileup", out_pileup, 0);

        // R2: valid samples with no open waveform are ignored
        idle(20, 1'b1);

        cfg_threshold = 100; cfg_win_len = 64;
        shape(80, 200, 0, 30, 400, 0, 0);
        run("single pulse R3", 80, 1'b0);

        // R3 baseline floor: 0..15 sum 120 -> 7
        for (int i = 0; i < 16; i++) w[i] = i;
        for (int i = 16; i < 40; i++) w[i] = 7 + ((i == 25) ? 100 : 0);
        run("baseline floor R3", 40, 1'b0);

        cfg_threshold = 2000;
        shape(60, 500, 0, 25, 300, 0, 0);
        run("no hit R5", 60, 1'b1);

        // R5 corrected exactly at threshold counts; one below does not
        cfg_threshold = 50;
        for (int i = 0; i < 30; i++) w[i] = 300;
        w[20] = 349; w[24] = 350;
        run("threshold equal R5", 30, 1'b0);

        // R6 double pulse
        cfg_threshold = 150;
        shape(120, 100, 0, 30, 600, 60, 600);
        run("pileup R6", 120, 1'b0);

        // R6 dip to exactly half is not a fall
        for (int i = 0; i < 40; i++) w[i] = 100;
        w[20] = 300; w[21] = 175; w[22] = 300; w[23] = 174; w[24] = 260;
        cfg_threshold = 150;
        run("half dip R6", 40, 1'b0);

        // re-crossing on the last sample
        for (int i = 0; i < 30; i++) w[i] = 100;
        w[20] = 400; w[29] = 400;
        run("pileup on end R8", 30, 1'b0);
        // first crossing on the last sample
        for (int i = 0; i < 30; i++) w[i] = 100;
        w[29] = 400;
        run("hit on end R5", 30, 1'b0);

        // R4 full scale positive and negative over 255 samples
        cfg_win_len = 255; cfg_threshold = 4000;
        for (int i = 0; i < 271; i++) w[i] = (i < 16) ? 0 : 4095;
        run("full scale R4", 271, 1'b0);
        for (int i = 0; i < 280; i++) w[i] = (i < 16) ? 4095 : 0;
        run("negative full scale R4", 280, 1'b0);

        // R9 short waveforms
        cfg_win_len = 64; cfg_threshold = 10;
        for (int i = 0; i < 10; i++) w[i] = 4000;
        run("short R9", 10, 1'b0);
        w[0] = 3000;
        run("start and end R9", 1, 1'b0);

        // R2 restart abandons the open waveform
        shape(50, 900, 0, 20, 700, 0, 0);
        send(50, 1'b0, 1'b0);
        shape(70, 300, 2, 35, 500, 0, 0);
        run("restart R2", 70, 1'b1);

        // random waveforms
        for (int t = 0; t < 40; t++) begin
            int n = $urandom_range(16, 320);
            int np = $urandom_range(0, 2);
            cfg_threshold = 12'($urandom_range(20, 400));
            cfg_win_len = 8'($urandom_range(1, 255));
            shape(n, $urandom_range(0, 3000), $urandom_range(0, 4),
                  $urandom_range(16, n), np > 0 ? $urandom_range(50, 1000) : 0,
                  $urandom_range(16, n), np > 1 ? $urandom_range(50, 1000) : 0);
            run("random R4 R5 R6", n, 1'b1);
            if (t % 8 == 0) idle(5, 1'b1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule